// File: doc/BRIEF.md
# Serial Audio Direction Control and Status Register

This block is the control and status register for one direction of a serial audio port. A parameter selects transmit or receive. It holds the run enable, the DMA request enable and one interrupt enable for each of five event flags. It also holds a FIFO watermark. From the FIFO fill level and the event strobes sent by the datapath, it produces an interrupt line, a DMA request line, a run indication and a FIFO flush command. The FIFO storage and the serial shifter sit outside the block.

Software uses a two-entry register port. Writes complete on the clock edge and reads are combinational. Software can stop the direction at any time, but the run indication waits for the datapath's end-of-frame strobe, so a frame is never cut in half. A software reset bit in the control word holds the whole block in reset for as long as it reads back 1.

Top module: `audio_chan_csr`

## Requirements
- R1: After reset, the control word (address 0) reads 0 except the live level flags, address 1 reads 0, and `irq`, `dma_req`, `run_active` and `fifo_flush` are 0.
- R2: The sticky flags are fifo error (bit 14), sync error (bit 15) and word start (bit 16). Each is set in the cycle after its strobe. Writing 1 to its bit at address 0 clears it; writing 0 leaves it unchanged.
- R3: If a strobe and a write-1 clear of the same sticky flag arrive in the same cycle, the flag stays set.
- R4: The level flags are FIFO request (bit 12) and FIFO warning (bit 13), and both follow the fill level live. On transmit, request is level <= watermark and warning is level == 0. On receive, request is level > watermark and warning is level == DEPTH. Writes to bits 12 and 13 have no effect.
- R5: The interrupt enable for flag bit 12+i sits at bit 4+i. `irq` is high exactly when some flag is set together with its enable.
- R6: `dma_req` equals the FIFO request flag ANDed with the DMA enable (bit 1).
- R7: Writing 1 to bit 24 drives `fifo_flush` high for exactly one cycle. Bit 24 always reads back 0.
- R8: Writing 1 to bit 0 sets `run_active` (read back at bit 0). Writing 0 keeps it high until the first `frame_end` strobe after that write. A `frame_end` in the same cycle as the disabling write does not count, and writing 1 again cancels the pending stop.
- R9: While bit 25 reads 1, all other state is held at reset, writes to other fields and event strobes are ignored, and `fifo_flush` is high. Writing 0 to bit 25 releases the reset.
- R10: Address 1 holds the watermark in bits [log2(DEPTH)-1:0]. It reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control/status, 1 watermark |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Combinational read data for `reg_addr` |
| fill_level | input | log2(DEPTH+1) | Current FIFO fill level |
| evt_word_start | input | 1 | Strobe: a word started |
| evt_sync_err | input | 1 | Strobe: frame sync error |
| evt_fifo_err | input | 1 | Strobe: underrun (transmit) or overflow (receive) |
| frame_end | input | 1 | Strobe: current frame finished |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |
| run_active | output | 1 | Direction is running |
| fifo_flush | output | 1 | Empty the FIFO pointers |

## Verification
The bench sweeps every watermark against every fill level, including both empty and full, for one transmit and one receive instance. A swapped compare or an off-by-one at the watermark would show up as a wrong request or warning flag. It also collides a strobe with its own write-1 clear; a design that lets the clear win would lose the event. For the stop sequence, the bench checks a `frame_end` in the same cycle as the disabling write and a re-enable before the frame ends; a design that stops at once or stops on a stale frame boundary would drop `run_active` early. While the software reset is held, it tries writes and strobes; a leaky reset would let a flag or the watermark change.

// File: rtl/audio_chan_csr_pkg.sv
// Package: field positions of the control/status word and flag indices.
// Assumes a data width of at least 26 bits.
package audio_chan_csr_pkg;
    localparam int NFLAG      = 5;
    localparam int FLG_REQ    = 0;
    localparam int FLG_WARN   = 1;
    localparam int FLG_FERR   = 2;
    localparam int FLG_SERR   = 3;
    localparam int FLG_WSTART = 4;
    localparam int NSTICKY    = 3;
    localparam int STICKY_LSB = FLG_FERR;
    localparam int BIT_RUN    = 0;
    localparam int BIT_DMA    = 1;
    localparam int IE_LSB     = 4;
    localparam int FLAG_LSB   = 12;
    localparam int BIT_FLUSH  = 24;
    localparam int BIT_SRST   = 25;
    typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/audio_chan_level.sv
// Level flags: derives the FIFO request and warning flags from the live fill
// level and the watermark. IS_TX picks the compare direction. Purely
// combinational; assumes fill_level never exceeds DEPTH.
module audio_chan_level #(
    parameter int DEPTH = 32,
    parameter bit IS_TX = 1'b1,
    parameter int LVL_W = 6,
    parameter int WM_W  = 5
) (
    input  logic [LVL_W-1:0] fill_level,
    input  logic [WM_W-1:0]  watermark,
    output logic             lvl_req,
    output logic             lvl_warn
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    generate
        if (IS_TX) begin : g_tx
            // Transmit: ask for data at or below the mark, warn when empty
            always_comb begin
                lvl_req  = fill_level <= LVL_W'(watermark);
                lvl_warn = fill_level == '0;
            end
        end else begin : g_rx
            // Receive: ask for draining above the mark, warn when full
            always_comb begin
                lvl_req  = fill_level > LVL_W'(watermark);
                lvl_warn = fill_level == FULL_LVL;
            end
        end
    endgenerate
endmodule

// File: rtl/audio_chan_sticky.sv
// Sticky flags: each bit is set by its event strobe and cleared by a
// write-1. The event wins over a clear in the same cycle. clr_all wipes every
// bit (software reset) and wins over everything.
module audio_chan_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_all,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] w1c,
    output logic [N-1:0] flags
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            // One flag: reset, then set on event, else clear on write-1
            always_ff @(posedge clk) begin
                if (!rst_n || clr_all) flags[i] <= 1'b0;
                else if (evt[i])       flags[i] <= 1'b1;
                else if (w1c[i])       flags[i] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/audio_chan_run.sv
// Run control: sets at once on enable. A disable only arms a pending stop,
// which takes effect on the next frame_end strobe. Assumes a frame_end
// strobe in the same cycle as the disabling write belongs to the
// old frame and is ignored.
module audio_chan_run (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_all,
    input  logic set_run,
    input  logic clr_run,
    input  logic frame_end,
    output logic active
);
    logic stop_pend;

    // Run state and pending-stop bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            active    <= 1'b0;
            stop_pend <= 1'b0;
        end else if (set_run) begin
            active    <= 1'b1;
            stop_pend <= 1'b0;
        end else if (clr_run) begin
            stop_pend <= active;
        end else if (frame_end && stop_pend) begin
            active    <= 1'b0;
            stop_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/audio_chan_csr.sv
// Control/status register for one serial audio direction. It holds run, DMA
// and interrupt enables, sticky and level event flags, the watermark, and the
// FIFO flush and software reset controls. Address 0 is the control/status
// word and address 1 is the watermark. Reads are combinational.
module audio_chan_csr
    import audio_chan_csr_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter bit IS_TX = 1'b1,
    parameter int DW    = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_wr,
    input  logic                         reg_addr,
    input  logic [DW-1:0]                reg_wdata,
    output logic [DW-1:0]                reg_rdata,
    input  logic [$clog2(DEPTH+1)-1:0]   fill_level,
    input  logic                         evt_word_start,
    input  logic                         evt_sync_err,
    input  logic                         evt_fifo_err,
    input  logic                         frame_end,
    output logic                         irq,
    output logic                         dma_req,
    output logic                         run_active,
    output logic                         fifo_flush
);
    localparam int WM_W  = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH+1);

    logic              wr_ctrl, wr_wm, ctrl_wr_ok;
    logic              srst_q, flush_q, dma_en_q;
    flag_vec_t         ie_q, flags;
    logic [WM_W-1:0]   wm_q;
    logic              lvl_req, lvl_warn;
    logic [NSTICKY-1:0] sticky_q, sticky_evt, sticky_w1c;
    wire               unused_wdata = ^reg_wdata;

    assign wr_ctrl    = reg_wr && (reg_addr == 1'b0);
    assign wr_wm      = reg_wr && (reg_addr == 1'b1);
    assign ctrl_wr_ok = wr_ctrl && !srst_q;

    // Software reset bit: stays writable while held so that it can be released
    always_ff @(posedge clk) begin
        if (!rst_n)       srst_q <= 1'b0;
        else if (wr_ctrl) srst_q <= reg_wdata[BIT_SRST];
    end

    // Enables: DMA and interrupt enable fields
    always_ff @(posedge clk) begin
        if (!rst_n || srst_q) begin
            dma_en_q <= 1'b0;
            ie_q     <= '0;
        end else if (ctrl_wr_ok) begin
            dma_en_q <= reg_wdata[BIT_DMA];
            ie_q     <= reg_wdata[IE_LSB +: NFLAG];
        end
    end

    // Watermark register
    always_ff @(posedge clk) begin
        if (!rst_n || srst_q)          wm_q <= '0;
        else if (wr_wm)                wm_q <= reg_wdata[WM_W-1:0];
    end

    // Self-clearing flush: one-cycle pulse per write-1
    always_ff @(posedge clk) begin
        if (!rst_n) flush_q <= 1'b0;
        else        flush_q <= ctrl_wr_ok && reg_wdata[BIT_FLUSH];
    end

    assign sticky_evt = {evt_word_start, evt_sync_err, evt_fifo_err};
    assign sticky_w1c = ctrl_wr_ok ? reg_wdata[FLAG_LSB+STICKY_LSB +: NSTICKY]
                                   : '0;

    audio_chan_sticky #(.N(NSTICKY)) i_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (srst_q),
        .evt     (sticky_evt),
        .w1c     (sticky_w1c),
        .flags   (sticky_q)
    );

    audio_chan_level #(.DEPTH(DEPTH), .IS_TX(IS_TX), .LVL_W(LVL_W), .WM_W(WM_W)) i_level (
        .fill_level (fill_level),
        .watermark  (wm_q),
        .lvl_req    (lvl_req),
        .lvl_warn   (lvl_warn)
    );

    audio_chan_run i_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_all   (srst_q),
        .set_run   (ctrl_wr_ok && reg_wdata[BIT_RUN]),
        .clr_run   (ctrl_wr_ok && !reg_wdata[BIT_RUN]),
        .frame_end (frame_end),
        .active    (run_active)
    );

    assign flags      = {sticky_q, lvl_warn, lvl_req};
    assign irq        = |(flags & ie_q);
    assign dma_req    = dma_en_q && lvl_req;
    assign fifo_flush = flush_q || srst_q;

    // Read mux: control/status word or watermark
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == 1'b0) begin
            reg_rdata[BIT_RUN]             = run_active;
            reg_rdata[BIT_DMA]             = dma_en_q;
            reg_rdata[IE_LSB +: NFLAG]     = ie_q;
            reg_rdata[FLAG_LSB +: NFLAG]   = flags;
            reg_rdata[BIT_SRST]            = srst_q;
        end else begin
            reg_rdata[WM_W-1:0]            = wm_q;
        end
    end
endmodule

// File: rtl/audio_chan_csr_chk.sv
// Checker: temporal properties of the control/status register, bound to
// every instance of audio_chan_csr.
module audio_chan_csr_chk
    import audio_chan_csr_pkg::*;
#(
    parameter int DW = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr,
    input logic            reg_addr,
    input logic [DW-1:0]   reg_wdata,
    input logic            evt_word_start,
    input logic            frame_end,
    input logic            irq,
    input logic            dma_req,
    input logic            run_active,
    input logic            srst_q,
    input logic            dma_en_q,
    input flag_vec_t       flags
);
    logic srst_wr;
    assign srst_wr = reg_wr && (reg_addr == 1'b0) && reg_wdata[BIT_SRST];

    AST_DMA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> dma_en_q);  // R6

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_word_start && !srst_q && !srst_wr) |=> flags[FLG_WSTART]);  // R3

    AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_active && !frame_end && !srst_q && !srst_wr) |=> run_active);  // R8

    AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> (!run_active && !irq && !dma_req));  // R9

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != '0));  // R5
endmodule

bind audio_chan_csr audio_chan_csr_chk #(.DW(DW)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_wr         (reg_wr),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .evt_word_start (evt_word_start),
    .frame_end      (frame_end),
    .irq            (irq),
    .dma_req        (dma_req),
    .run_active     (run_active),
    .srst_q         (srst_q),
    .dma_en_q       (dma_en_q),
    .flags          (flags)
);

// File: tb/test_audio_chan_csr.sv
// Bench: one transmit and one receive instance sharing all inputs; sweeps
// watermark against fill level and walks the register controls.
module test_audio_chan_csr;
    localparam int DEPTH = 32;
    localparam int DW    = 32;
    localparam int LVL_W = $clog2(DEPTH+1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic             reg_addr = 1'b0;
    logic [DW-1:0]    reg_wdata = '0;
    logic [LVL_W-1:0] fill_level = LVL_W'(16);
    logic             evt_word_start = 1'b0, evt_sync_err = 1'b0, evt_fifo_err = 1'b0;
    logic             frame_end = 1'b0;
    logic [DW-1:0]    rd_tx, rd_rx;
    logic             irq_tx, irq_rx, dma_tx, dma_rx, run_tx, run_rx, fl_tx, fl_rx;
    int               n_chk = 0, n_fail = 0;
    bit               done = 1'b0;

    always #5 clk = ~clk;

    audio_chan_csr #(.DEPTH(DEPTH), .IS_TX(1'b1), .DW(DW)) i_audio_chan_csr (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rd_tx), .fill_level(fill_level),
        .evt_word_start(evt_word_start), .evt_sync_err(evt_sync_err),
        .evt_fifo_err(evt_fifo_err), .frame_end(frame_end), .irq(irq_tx),
        .dma_req(dma_tx), .run_active(run_tx), .fifo_flush(fl_tx));

    audio_chan_csr #(.DEPTH(DEPTH), .IS_TX(1'b0), .DW(DW)) i_audio_chan_csr_rx (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rd_rx), .fill_level(fill_level),
        .evt_word_start(evt_word_start), .evt_sync_err(evt_sync_err),
        .evt_fifo_err(evt_fifo_err), .frame_end(frame_end), .irq(irq_rx),
        .dma_req(dma_rx), .run_active(run_rx), .fifo_flush(fl_rx));

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // expected {warn, req} from the level rules
    function automatic logic [1:0] lvl_model(input bit tx, input int lvl, input int wm);
        if (tx) return {lvl == 0, lvl <= wm};
        else    return {lvl == DEPTH, lvl > wm};
    endfunction

    task automatic wr(input logic a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic sel(input logic a);
        reg_addr = a; #1;
    endtask

    task automatic pulse_evt(input int k);
        @(negedge clk);
        evt_fifo_err = (k == 2); evt_sync_err = (k == 3); evt_word_start = (k == 4);
        @(negedge clk);
        evt_fifo_err = 1'b0; evt_sync_err = 1'b0; evt_word_start = 1'b0;
    endtask

    task automatic pulse_frame_end();
        @(negedge clk); frame_end = 1'b1;
        @(negedge clk); frame_end = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [1:0] lt, lr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state (fill 16, watermark 0)
        sel(1'b0);
        chk("R1 ctrl tx", rd_tx, 32'h0);
        chk("R1 ctrl rx", rd_rx, 32'h1 << 12);
        chk("R1 outs tx", {irq_tx, dma_tx, run_tx, fl_tx}, 0);
        chk("R1 outs rx", {irq_rx, dma_rx, run_rx, fl_rx}, 0);
        sel(1'b1);
        chk("R1 wm", rd_tx, 0);

        // R4, R10: sweep every watermark against every level
        for (int wm = 0; wm < DEPTH; wm++) begin
            wr(1'b1, DW'(wm));
            sel(1'b1);
            chk("R10 wm tx", rd_tx, DW'(wm));
            chk("R10 wm rx", rd_rx, DW'(wm));
            sel(1'b0);
            for (int l = 0; l <= DEPTH; l++) begin
                fill_level = LVL_W'(l); #1;
                lt = lvl_model(1'b1, l, wm);
                lr = lvl_model(1'b0, l, wm);
                chk("R4 level tx", DW'(rd_tx[13:12]), DW'(lt));
                chk("R4 level rx", DW'(rd_rx[13:12]), DW'(lr));
            end
        end

        // R4: writing the level flag bits has no effect (tx level 0 -> both set)
        wr(1'b1, 32'd5);
        fill_level = '0;
        wr(1'b0, 32'h3 << 12);
        sel(1'b0);
        chk("R4 nowrite tx", DW'(rd_tx[13:12]), 32'h3);
        chk("R4 nowrite rx", DW'(rd_rx[13:12]), 32'h0);

        // R2: sticky set, write 0 keeps, write 1 clears
        for (int k = 2; k <= 4; k++) begin
            pulse_evt(k);
            sel(1'b0);
            chk("R2 set", DW'(rd_tx[16:14]), DW'(1 << (k - 2)));
            wr(1'b0, 32'h0);
            sel(1'b0);
            chk("R2 w0 keeps", DW'(rd_rx[16:14]), DW'(1 << (k - 2)));
            wr(1'b0, 32'h1 << (12 + k));
            sel(1'b0);
            chk("R2 w1c", DW'(rd_tx[16:14]), 32'h0);
        end

        // R3: event and clear in the same cycle -> event wins
        @(negedge clk);
        evt_word_start = 1'b1; reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 32'h1 << 16;
        @(negedge clk);
        evt_word_start = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        sel(1'b0);
        chk("R3 event wins tx", DW'(rd_tx[16]), 32'h1);
        chk("R3 event wins rx", DW'(rd_rx[16]), 32'h1);

        // R5: flags tx = 10111, rx = 10100 (level 0, wm 5, ws+ferr set)
        pulse_evt(2);
        for (int m = 0; m < 32; m++) begin
            wr(1'b0, DW'(m) << 4);
            chk("R5 irq tx", DW'(irq_tx), DW'((m & 5'b10111) != 0));
            chk("R5 irq rx", DW'(irq_rx), DW'((m & 5'b10100) != 0));
        end
        wr(1'b0, 32'h1F << 14);

        // R6: DMA request follows request flag when enabled
        wr(1'b1, 32'd10);
        wr(1'b0, 32'h2);
        for (int l = 0; l <= DEPTH; l++) begin
            fill_level = LVL_W'(l); #1;
            chk("R6 dma tx", DW'(dma_tx), DW'(l <= 10));
            chk("R6 dma rx", DW'(dma_rx), DW'(l > 10));
        end
        wr(1'b0, 32'h0);
        fill_level = LVL_W'(0); #1;
        chk("R6 dma off", DW'(dma_tx), 32'h0);

        // R7: flush pulse, reads back 0
        wr(1'b0, 32'h1 << 24);
        sel(1'b0);
        chk("R7 flush high", DW'(fl_tx), 32'h1);
        chk("R7 flush reads 0", DW'(rd_tx[24]), 32'h0);
        @(negedge clk);
        chk("R7 flush one cycle", DW'(fl_tx), 32'h0);

        // R8: enable drains until frame end
        wr(1'b0, 32'h1);
        sel(1'b0);
        chk("R8 run set", DW'({run_tx, rd_tx[0]}), 32'h3);
        wr(1'b0, 32'h0);
        repeat (3) @(negedge clk);
        chk("R8 run holds", DW'({run_tx, rd_rx[0]}), 32'h3);
        pulse_frame_end();
        chk("R8 stops at frame end", DW'({run_tx, run_rx}), 32'h0);
        wr(1'b0, 32'h1);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = 32'h0; frame_end = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; frame_end = 1'b0;
        chk("R8 same-cycle frame end ignored", DW'(run_tx), 32'h1);
        wr(1'b0, 32'h1);
        pulse_frame_end();
        chk("R8 re-enable cancels stop", DW'(run_tx), 32'h1);
        wr(1'b0, 32'h0);
        pulse_frame_end();
        chk("R8 final stop", DW'(run_tx), 32'h0);

        // R9: software reset holds everything
        fill_level = LVL_W'(16);
        wr(1'b1, 32'd7);
        wr(1'b0, 32'h1F3);
        pulse_evt(4);
        wr(1'b0, 32'h1 << 25);
        chk("R9 flush while held", DW'(fl_tx), 32'h1);
        @(negedge clk);
        sel(1'b0);
        chk("R9 ctrl tx", rd_tx, 32'h1 << 25);
        chk("R9 ctrl rx", rd_rx, (32'h1 << 25) | (32'h1 << 12));
        chk("R9 outs", DW'({irq_tx, dma_tx, run_tx}), 32'h0);
        wr(1'b1, 32'd9);
        pulse_evt(3);
        sel(1'b1);
        chk("R9 wm ignored", rd_tx, 32'h0);
        sel(1'b0);
        chk("R9 event ignored", DW'(rd_tx[16:14]), 32'h0);
        wr(1'b0, 32'h0);
        sel(1'b0);
        chk("R9 released", rd_tx, 32'h0);
        chk("R9 flush off", DW'(fl_tx), 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule